// File: doc/BRIEF.md
# Paged Memory Mapper with Passthrough Mode

This block widens a 16-bit processor address to a 19-bit physical address. The 64K processor space is split into sixteen 4K pages. Each page has its own 8-bit map register, and the top four processor address bits pick which register translates the current access. The low twelve address bits go through unchanged. A map register also carries a protect flag, which the memory decoder outside the block uses to block writes to that page.

Software programs the registers through a small access port. The port has a chip select, a read/write line, a write strobe, a 4-bit register index, and byte-wide data in and data out. While the chip select is active the block is in access mode. With the chip select idle, the map-enable input chooses between map mode (translation through the registers) and passthrough. In passthrough the processor page number appears unchanged at the bottom of the physical page field.

The bit layout inside a register is not linear. The four low physical page bits take register bits 2, 1, 0 and 3, in that order. Because of this, the table that makes map mode behave like passthrough is not an identity table. Software typically loads that table before it turns mapping on, so the running code sees no change at the moment mapping is enabled.

Top module: `page_mapper`

## Requirements
- R1: After synchronous reset every map register holds 00 hex, and `map_active` is low while `map_en` is low.
- R2: When `acc_sel`=1, `acc_rd`=0 and `acc_stb`=1 on a rising clock edge, the byte on `acc_wdata` is stored in the register numbered by `acc_idx`.
- R3: A cycle with `acc_sel`=1 and `acc_rd`=0 but `acc_stb`=0 changes no register.
- R4: With `acc_sel`=1 and `acc_rd`=1, `acc_rdata` shows the selected register exactly as written, in the same cycle. Otherwise `acc_rdata` is 00 hex.
- R5: `map_active` is 1 exactly when `acc_sel`=0 and `map_en`=1.
- R6: When `map_active` is 0, `phys_addr[15:12]` equals `cpu_addr[15:12]`, `phys_addr[18:16]` is 0 and `page_prot` is 0.
- R7: In map mode the register selected by `cpu_addr[15:12]` drives the page field. For a register byte b, `phys_addr[18:16]` = b[6:4] and `phys_addr[15:12]` = {b[2], b[1], b[0], b[3]}.
- R8: In map mode `page_prot` equals bit 7 of the selected register.
- R9: `phys_addr[11:0]` always equals `cpu_addr[11:0]`.
- R10: When registers 0 to 15 are loaded with 00, 08, 01, 09, 02, 0A, 03, 0B, 04, 0C, 05, 0D, 06, 0E, 07, 0F hex, map mode gives the same physical address as passthrough for every page.
- R11: While `acc_sel`=1 the outputs follow passthrough even if `map_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 1 | Register access select, active high |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_stb | input | 1 | Write strobe, active high |
| acc_idx | input | 4 | Register index for access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, 00 hex when not reading |
| map_en | input | 1 | Mapping enable |
| cpu_addr | input | 16 | Processor address |
| phys_addr | output | 19 | Physical address |
| page_prot | output | 1 | Protect flag of the selected page |
| map_active | output | 1 | High in map mode |

## Verification
Translation is tried with bytes that set a single page bit at a time. This shows whether each data bit reaches its intended physical bit, and whether the out-of-sequence bit 3 lands at physical bit 12. Bytes with mixed high and low bits, with and without the protect bit, separate the high page field from the protect flag. The full passthrough table is loaded and every page is compared with passthrough, which catches both register-select errors and scramble errors. Strobe-less writes, and map enable held high during access, show that gating and mode priority are handled correctly.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int MAP_ADDR_W = 16;
    localparam int MAP_OFS_W  = 12;
    localparam int MAP_PHYS_W = 19;
    localparam int MAP_IDX_W  = MAP_ADDR_W - MAP_OFS_W;
    localparam int MAP_NREG   = 1 << MAP_IDX_W;
    localparam int MAP_EXT_W  = MAP_PHYS_W - MAP_ADDR_W;
    localparam int MAP_PAGE_W = MAP_PHYS_W - MAP_OFS_W;

    // one map register: protect flag, high page bits, scrambled low nibble
    typedef struct packed {
        logic                 prot;
        logic [MAP_EXT_W-1:0] hi;
        logic [3:0]           lo;
    } map_entry_t;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_MAP    = 2'd1,
        MODE_ACCESS = 2'd2
    } map_mode_t;

    // physical page number produced by one register byte
    function automatic logic [MAP_PAGE_W-1:0] entry_page(map_entry_t e);
        return {e.hi, e.lo[2], e.lo[1], e.lo[0], e.lo[3]};
    endfunction

    // physical page number used when translation is bypassed
    function automatic logic [MAP_PAGE_W-1:0] pass_page(logic [MAP_IDX_W-1:0] p);
        return {{MAP_EXT_W{1'b0}}, p};
    endfunction

endpackage

// File: rtl/map_regfile.sv
module map_regfile
    import mapper_pkg::*;
#(
    parameter int NREG  = MAP_NREG,
    parameter int IDX_W = MAP_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  map_entry_t       wentry,
    input  logic [IDX_W-1:0] ridx_acc,
    input  logic [IDX_W-1:0] ridx_xl,
    output map_entry_t       rentry_acc,
    output map_entry_t       rentry_xl
);

    map_entry_t regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                regs[g] <= wentry;
            end
        end
    end

    always_comb begin
        rentry_acc = regs[ridx_acc];
        rentry_xl  = regs[ridx_xl];
    end

endmodule

// File: rtl/map_mode_ctl.sv
module map_mode_ctl
    import mapper_pkg::*;
(
    input  logic      sel,
    input  logic      rd,
    input  logic      stb,
    input  logic      en,
    output map_mode_t mode,
    output logic      wr_fire,
    output logic      rd_fire
);

    always_comb begin
        if (sel)     mode = MODE_ACCESS;
        else if (en) mode = MODE_MAP;
        else         mode = MODE_PASS;
        wr_fire = sel && !rd && stb;
        rd_fire = sel && rd;
    end

endmodule

// File: rtl/map_xlate.sv
module map_xlate
    import mapper_pkg::*;
#(
    parameter int ADDR_W = MAP_ADDR_W,
    parameter int OFS_W  = MAP_OFS_W,
    parameter int PHYS_W = MAP_PHYS_W
) (
    input  map_mode_t         mode,
    input  map_entry_t        entry,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [PHYS_W-1:0] paddr,
    output logic              prot,
    output logic              active
);

    localparam int PG_W = PHYS_W - OFS_W;

    logic [PG_W-1:0] page;

    always_comb begin
        active = (mode == MODE_MAP);
        if (active) begin
            page = entry_page(entry);
            prot = entry.prot;
        end else begin
            page = pass_page(vaddr[ADDR_W-1:OFS_W]);
            prot = 1'b0;
        end
        paddr = {page, vaddr[OFS_W-1:0]};
    end

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import mapper_pkg::*;
#(
    parameter int ADDR_W = MAP_ADDR_W,
    parameter int OFS_W  = MAP_OFS_W,
    parameter int PHYS_W = MAP_PHYS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_sel,
    input  logic              acc_rd,
    input  logic              acc_stb,
    input  logic [3:0]        acc_idx,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic              map_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              page_prot,
    output logic              map_active
);

    localparam int IDX_W = ADDR_W - OFS_W;
    localparam int NREG  = 1 << IDX_W;

    map_mode_t  mode;
    logic       wr_fire, rd_fire;
    map_entry_t ent_acc, ent_xl;

    map_mode_ctl u_mode (
        .sel     (acc_sel),
        .rd      (acc_rd),
        .stb     (acc_stb),
        .en      (map_en),
        .mode    (mode),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire)
    );

    map_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_fire),
        .widx       (acc_idx),
        .wentry     (map_entry_t'(acc_wdata)),
        .ridx_acc   (acc_idx),
        .ridx_xl    (cpu_addr[ADDR_W-1:OFS_W]),
        .rentry_acc (ent_acc),
        .rentry_xl  (ent_xl)
    );

    map_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PHYS_W(PHYS_W)) u_xl (
        .mode   (mode),
        .entry  (ent_xl),
        .vaddr  (cpu_addr),
        .paddr  (phys_addr),
        .prot   (page_prot),
        .active (map_active)
    );

    assign acc_rdata = rd_fire ? 8'(ent_acc) : 8'h00;

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_sel,
    input logic        acc_rd,
    input logic        acc_stb,
    input logic [3:0]  acc_idx,
    input logic [7:0]  acc_wdata,
    input logic [7:0]  acc_rdata,
    input logic        map_en,
    input logic [15:0] cpu_addr,
    input logic [18:0] phys_addr,
    input logic        page_prot,
    input logic        map_active
);

    // R5, R11: access select always wins over mapping
    assert_sel_blocks_map_R11: assert property (@(posedge clk) disable iff (rst)
        acc_sel |-> !map_active);

    assert_en_maps_R5: assert property (@(posedge clk) disable iff (rst)
        (!acc_sel && map_en) |-> map_active);

    // R6: bypassed page field and no protect
    assert_pass_page_R6: assert property (@(posedge clk) disable iff (rst)
        !map_active |-> (phys_addr[18:12] == {3'b000, cpu_addr[15:12]} && !page_prot));

    // R9: offset untouched
    assert_offset_R9: assert property (@(posedge clk) disable iff (rst)
        phys_addr[11:0] == cpu_addr[11:0]);

    // R2, R4: a written byte reads back next cycle
    assert_readback_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(acc_sel && !acc_rd && acc_stb) && !$past(rst) && acc_sel && acc_rd
         && acc_idx == $past(acc_idx)) |-> acc_rdata == $past(acc_wdata));

    // R4: idle read port is zero
    assert_idle_rdata_R4: assert property (@(posedge clk) disable iff (rst)
        !(acc_sel && acc_rd) |-> acc_rdata == 8'h00);

endmodule

bind page_mapper page_mapper_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_sel    (acc_sel),
    .acc_rd     (acc_rd),
    .acc_stb    (acc_stb),
    .acc_idx    (acc_idx),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .map_en     (map_en),
    .cpu_addr   (cpu_addr),
    .phys_addr  (phys_addr),
    .page_prot  (page_prot),
    .map_active (map_active)
);

// File: tb/test_page_mapper.sv
`timescale 1ns/1ps
module test_page_mapper;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_sel, acc_rd, acc_stb;
    logic [3:0]  acc_idx;
    logic [7:0]  acc_wdata;
    logic [7:0]  acc_rdata;
    logic        map_en;
    logic [15:0] cpu_addr;
    logic [18:0] phys_addr;
    logic        page_prot, map_active;

    always #5 clk = ~clk;

    page_mapper i_page_mapper (
        .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_rd(acc_rd),
        .acc_stb(acc_stb), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .map_en(map_en), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .page_prot(page_prot), .map_active(map_active)
    );

    typedef struct {
        string       tag;
        logic [18:0] phys;
        logic        prot;
        logic        act;
        logic [7:0]  rd;
    } exp_t;

    exp_t        sb[$];
    int          errors = 0;
    int          checks = 0;
    logic [7:0]  mdl [16];
    bit          done = 0;

    // expected page number from a register byte (R7 layout)
    function automatic logic [6:0] byte_page(logic [7:0] b);
        return {b[6:4], b[2], b[1], b[0], b[3]};
    endfunction

    // driver: apply inputs at falling edge and queue what the outputs must be
    task automatic drive_check(string tag, logic sel, logic rd, logic [3:0] idx,
                               logic en, logic [15:0] a);
        exp_t e;
        @(negedge clk);
        acc_sel = sel; acc_rd = rd; acc_stb = 1'b0; acc_idx = idx;
        map_en = en; cpu_addr = a;
        e.tag = tag;
        e.act = !sel && en;
        if (e.act) begin
            e.phys = {byte_page(mdl[a[15:12]]), a[11:0]};
            e.prot = mdl[a[15:12]][7];
        end else begin
            e.phys = {3'b000, a};
            e.prot = 1'b0;
        end
        e.rd = (sel && rd) ? mdl[idx] : 8'h00;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    task automatic reg_write(logic [3:0] idx, logic [7:0] d, logic stb);
        @(negedge clk);
        acc_sel = 1'b1; acc_rd = 1'b0; acc_stb = stb; acc_idx = idx; acc_wdata = d;
        @(negedge clk);
        acc_stb = 1'b0; acc_sel = 1'b0; acc_rd = 1'b1;
        if (stb) mdl[idx] = d;
    endtask

    // monitor: pop expected items and compare
    initial begin
        forever begin
            wait (sb.size() > 0);
            #2;
            begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (phys_addr !== e.phys || page_prot !== e.prot ||
                    map_active !== e.act || acc_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s: phys=%h prot=%b act=%b rd=%h expected phys=%h prot=%b act=%b rd=%h",
                             e.tag, phys_addr, page_prot, map_active, acc_rdata,
                             e.phys, e.prot, e.act, e.rd);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        rst = 1'b1; acc_sel = 0; acc_rd = 1; acc_stb = 0; acc_idx = 0;
        acc_wdata = 0; map_en = 0; cpu_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        drive_check("R1 idle after reset", 0, 1, 4'd0, 0, 16'h3123);
        drive_check("R1 reg5 cleared", 1, 1, 4'd5, 0, 16'h0000);
        drive_check("R1 map of cleared reg", 0, 1, 4'd0, 1, 16'hB456);

        // R6, R9: passthrough with varied addresses
        drive_check("R6 pass F", 0, 1, 4'd0, 0, 16'hFABC);
        drive_check("R9 pass offset", 0, 1, 4'd0, 0, 16'h8FFF);

        // R2, R4: write then read back
        reg_write(4'd3, 8'hA5, 1'b1);
        drive_check("R2 R4 readback reg3", 1, 1, 4'd3, 0, 16'h0000);
        drive_check("R4 no read when rd low", 1, 0, 4'd3, 0, 16'h0000);
        drive_check("R4 rdata zero when idle", 0, 1, 4'd3, 0, 16'h0000);

        // R3: strobe low ignored
        reg_write(4'd3, 8'h11, 1'b0);
        drive_check("R3 no-strobe write ignored", 1, 1, 4'd3, 0, 16'h0000);

        // R7, R8: single-bit bytes and mixed
        reg_write(4'd1, 8'h08, 1'b1);
        drive_check("R7 bit3 to phys12", 0, 1, 4'd0, 1, 16'h1234);
        reg_write(4'd2, 8'h01, 1'b1);
        drive_check("R7 bit0 to phys13", 0, 1, 4'd0, 1, 16'h2ABC);
        reg_write(4'd4, 8'h04, 1'b1);
        drive_check("R7 bit2 to phys15", 0, 1, 4'd0, 1, 16'h4001);
        reg_write(4'd6, 8'h70, 1'b1);
        drive_check("R7 high bits", 0, 1, 4'd0, 1, 16'h6FFF);
        drive_check("R8 R7 mixed with protect", 0, 1, 4'd0, 1, 16'h3777);
        reg_write(4'd7, 8'h80, 1'b1);
        drive_check("R8 protect only", 0, 1, 4'd0, 1, 16'h7000);
        drive_check("R6 protect masked in pass", 0, 1, 4'd0, 0, 16'h7000);

        // R5, R11: access select wins over map enable
        drive_check("R11 access overrides map", 1, 1, 4'd3, 1, 16'h3555);
        drive_check("R5 map again", 0, 1, 4'd0, 1, 16'h3555);

        // R10: passthrough table
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = 4'(i);
            reg_write(v, {4'h0, v[0], v[3:1]}, 1'b1);
        end
        for (int i = 0; i < 16; i++) begin
            drive_check($sformatf("R10 table page %0d", i), 0, 1, 4'd0, 1,
                        {4'(i), 12'h5A5});
            if (phys_addr !== {3'b000, 4'(i), 12'h5A5}) begin
                errors++;
                $display("FAIL R10 identity page %0d: phys=%h expected %h", i,
                         phys_addr, {3'b000, 4'(i), 12'h5A5});
            end
            checks++;
        end

        // R1: reset clears registers again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        drive_check("R1 reset clears reg3", 1, 1, 4'd3, 0, 16'h0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule